// File: doc/BRIEF.md
# External Event Counter with Compare-Clear

This block counts edges of an asynchronous event signal rather than clock cycles. The event line passes through a two-flop synchronizer. Its edges are qualified by a two-bit select field, and each qualified edge advances a 16-bit count.

Software programs a compare register through a write strobe. The compare value reaches the matching logic only through an internal buffer, which is reloaded on every qualified edge. When a qualified edge arrives while the count equals the buffered value, the count returns to zero and a one-clock interrupt pulse is raised. After the first wrap, the interrupt repeats every compare+1 qualified edges.

Enabling the block parks the count at all ones, so the first qualified edge lands on zero. Disabling it freezes the count.

Top module: `evt_edge_counter`

## Requirements
- R1: After reset, `count` is 0000H, `match_irq` is 0 and `cmp_active` is 0000H.
- R2: In the cycle after `cnt_en` rises from 0 to 1, `count` is FFFFH and `cmp_active` holds the compare register value.
- R3: `count` changes only on a qualified edge or on the enable rise. It never advances on clock cycles alone.
- R4: On a qualified edge with `count` not equal to `cmp_active`, `count` increments by one, wrapping FFFFH to 0000H.
- R5: On a qualified edge with `count` equal to `cmp_active`, `count` becomes 0000H and `match_irq` is 1 for that one cycle. At all other times `match_irq` is 0. After the first wrap, interrupts come every compare+1 qualified edges.
- R6: Every qualified edge copies the compare register (as held before that cycle's write) into `cmp_active`.
- R7: With `edge_sel` = 00, no edge is qualified and `count` does not move.
- R8: `edge_sel` = 01 qualifies rising edges, 10 qualifies falling edges and 11 qualifies both edges of `evt_in`.
- R9: `evt_in` is sampled by two flops, and each edge is compared against the previous synchronized sample. A change of `evt_in` set up before clock edge k changes `count` at clock edge k+2, and one input edge gives exactly one count.
- R10: While `cnt_en` is 0, `count` holds its value and no interrupt is raised.
- R11: A compare write is stored at once but reaches `cmp_active` only at the next qualified edge or enable rise.
- R12: With a compare value of 0000H, every qualified edge after the first gives an interrupt, and `count` stays at 0000H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counting enable; a rise parks the count at FFFFH |
| edge_sel | input | 2 | Qualifying edge: 00 none, 01 rising, 10 falling, 11 both |
| evt_in | input | 1 | Raw asynchronous event input |
| cmp_wdata | input | 16 | Compare value to store |
| cmp_wr | input | 1 | Write strobe for the compare register |
| count | output | 16 | Current event count |
| match_irq | output | 1 | One-cycle compare-match interrupt |
| cmp_active | output | 16 | Buffered compare value used for matching |

## Verification
The assertions check these properties on every cycle:
- An interrupt always coincides with a zero count and with a qualified edge in the previous cycle.
- The count and the compare buffer stay still when there is neither a qualified edge nor an enable rise.
- An enable rise parks the count at all ones.
- Select value 00 never qualifies an edge.

Some behaviour only the bench scenarios can show, with a cycle-accurate model compared on every clock:
- the two-cycle synchronizer latency;
- which edges each select value counts;
- the compare+1 interrupt period;
- the deferred effect of compare writes;
- the stuck-at-zero behaviour with a zero compare value.

// File: rtl/eec_pkg.sv
package eec_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    function automatic logic edge_pass(input edge_sel_e sel, input logic rise, input logic fall);
        logic hit;
        case (sel)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/eec_edge_qual.sv
module eec_edge_qual
    import eec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_i,
    input  logic [1:0] sel_i,
    output logic       qual_o
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [LAST:0] chain;
        logic          prev;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic        now_s;
    logic        rise_s, fall_s;

    assign now_s = st_q.chain[LAST];

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[LAST-1:0], raw_i};
        st_d.prev  = now_s;
        rise_s     = now_s & ~st_q.prev;
        fall_s     = ~now_s & st_q.prev;
        qual_o     = edge_pass(edge_sel_e'(sel_i), rise_s, fall_s);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_sel_none_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == EDGE_NONE) |-> !qual_o);

    assert_edge_needs_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> (now_s != st_q.prev));

endmodule

// File: rtl/eec_count_core.sv
module eec_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             qual_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             wr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic [CNT_W-1:0] buf_o
);

    localparam logic [CNT_W-1:0] PARK = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp_buf;
        logic [CNT_W-1:0] cmp_reg;
        logic             irq;
        logic             en;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        en_rise;
    logic        step;

    assign en_rise = en_i & ~st_q.en;
    assign step    = en_i & st_q.en & qual_i;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.en  = en_i;
        if (wr_i) begin
            st_d.cmp_reg = wdata_i;
        end
        if (en_rise) begin
            st_d.cnt     = PARK;
            st_d.cmp_buf = st_q.cmp_reg;
        end else if (step) begin
            st_d.cmp_buf = st_q.cmp_reg;
            if (st_q.cnt == st_q.cmp_buf) begin
                st_d.cnt = '0;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign irq_o = st_q.irq;
    assign buf_o = st_q.cmp_buf;

    assert_irq_with_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cnt_o == '0));

    assert_irq_after_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(qual_i && en_i));

    assert_hold_no_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !en_rise) |=> $stable(cnt_o));

    assert_buf_only_on_transfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !en_rise) |=> $stable(buf_o));

    assert_park_on_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (cnt_o == PARK));

    assert_quiet_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !irq_o);

endmodule

// File: rtl/evt_edge_counter.sv
module evt_edge_counter #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [1:0]       edge_sel,
    input  logic             evt_in,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             cmp_wr,
    output logic [CNT_W-1:0] count,
    output logic             match_irq,
    output logic [CNT_W-1:0] cmp_active
);

    logic qual_s;

    eec_edge_qual #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (evt_in),
        .sel_i (edge_sel),
        .qual_o(qual_s)
    );

    eec_count_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (cnt_en),
        .qual_i (qual_s),
        .wdata_i(cmp_wdata),
        .wr_i   (cmp_wr),
        .cnt_o  (count),
        .irq_o  (match_irq),
        .buf_o  (cmp_active)
    );

endmodule

// File: tb/sim_evt_edge_counter.sv
`timescale 1ns/1ps
module sim_evt_edge_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [1:0]  edge_sel = 2'b00;
    logic        evt_in = 1'b0;
    logic [15:0] cmp_wdata = 16'h0000;
    logic        cmp_wr = 1'b0;
    logic [15:0] count;
    logic        match_irq;
    logic [15:0] cmp_active;

    int checks = 0;
    int errors = 0;
    int irq_total = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evt_edge_counter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .edge_sel  (edge_sel),
        .evt_in    (evt_in),
        .cmp_wdata (cmp_wdata),
        .cmp_wr    (cmp_wr),
        .count     (count),
        .match_irq (match_irq),
        .cmp_active(cmp_active)
    );

    // behavioural reference: raw-sample history plus integer counter state
    bit hist[$] = '{0, 0, 0};
    int m_cnt = 0, m_buf = 0, m_reg = 0;
    bit m_irq = 0, m_en = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{0, 0, 0};
            m_cnt = 0; m_buf = 0; m_reg = 0; m_irq = 0; m_en = 0;
        end else begin
            bit cur, old, q, was_en;
            int reg_before;
            cur = hist[1];
            old = hist[0];
            case (edge_sel)
                2'b01:   q = cur && !old;
                2'b10:   q = !cur && old;
                2'b11:   q = cur != old;
                default: q = 0;
            endcase
            was_en = m_en;
            reg_before = m_reg;
            m_irq = 0;
            if (cnt_en && !was_en) begin
                m_cnt = 65535;
                m_buf = reg_before;
            end else if (cnt_en && q) begin
                if (m_cnt == m_buf) begin
                    m_cnt = 0;
                    m_irq = 1;
                end else begin
                    m_cnt = (m_cnt + 1) % 65536;
                end
                m_buf = reg_before;
            end
            if (cmp_wr) m_reg = cmp_wdata;
            m_en = cnt_en;
            hist.push_back(evt_in);
            void'(hist.pop_front());
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(count == m_cnt[15:0], "R4 count vs model", count, m_cnt);
            check(match_irq == m_irq, "R5 irq vs model", match_irq, m_irq);
            check(cmp_active == m_buf[15:0], "R6 buffer vs model", cmp_active, m_buf);
            if (match_irq) irq_total++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cmp(input logic [15:0] v);
        @(negedge clk);
        cmp_wdata = v;
        cmp_wr = 1'b1;
        @(negedge clk);
        cmp_wr = 1'b0;
    endtask

    task automatic restart;
        @(negedge clk);
        cnt_en = 1'b0;
        cyc(1);
        cnt_en = 1'b1;
        cyc(2);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            evt_in = 1'b1;
            cyc(3);
            evt_in = 1'b0;
            cyc(3);
        end
        cyc(2);
    endtask

    initial begin
        cyc(3);
        check(count == 16'h0 && match_irq == 1'b0 && cmp_active == 16'h0, "R1 reset", count, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(2);
        check(count == 16'h0, "R1 after release", count, 0);

        // R2 park and buffer load on enable
        write_cmp(16'd3);
        edge_sel = 2'b01;
        restart();
        check(count == 16'hFFFF, "R2 park", count, 16'hFFFF);
        check(cmp_active == 16'd3, "R2 buffer load", cmp_active, 3);

        // R3 no count from clocks alone
        cyc(20);
        check(count == 16'hFFFF, "R3 idle clocks", count, 16'hFFFF);

        // R4 R5 period: irq at edges 5, 9, 13
        irq_total = 0;
        pulses(13);
        check(irq_total == 3, "R5 irq period", irq_total, 3);
        check(count == 16'h0, "R5 count after match", count, 0);

        // R9 latency: two clock edges of sync, counted on the third
        pulses(1);
        check(count == 16'h1, "R4 increment", count, 1);
        @(negedge clk);
        evt_in = 1'b1;
        cyc(1);
        check(count == 16'h1, "R9 after edge 1", count, 1);
        cyc(1);
        check(count == 16'h1, "R9 after edge 2", count, 1);
        cyc(1);
        check(count == 16'h2, "R9 after edge 3", count, 2);
        cyc(5);
        check(count == 16'h2, "R9 one count per edge", count, 2);
        evt_in = 1'b0;
        cyc(5);

        // R8 select modes with a large compare
        write_cmp(16'd100);
        edge_sel = 2'b10;
        restart();
        pulses(4);
        check(count == 16'd3, "R8 falling", count, 3);
        edge_sel = 2'b11;
        restart();
        pulses(4);
        check(count == 16'd7, "R8 both", count, 7);
        edge_sel = 2'b01;
        restart();
        pulses(2);
        check(count == 16'd1, "R8 rising", count, 1);

        // R7 select none
        edge_sel = 2'b00;
        pulses(3);
        check(count == 16'd1, "R7 none inhibits", count, 1);
        edge_sel = 2'b01;

        // R11 write defers to next transfer
        write_cmp(16'd2);
        cyc(3);
        check(cmp_active == 16'd100, "R11 buffer unchanged", cmp_active, 100);
        pulses(1);
        check(cmp_active == 16'd2, "R11 buffer after edge", cmp_active, 2);
        check(count == 16'd2, "R6 count after transfer", count, 2);

        // R10 disabled hold
        @(negedge clk);
        cnt_en = 1'b0;
        irq_total = 0;
        pulses(6);
        check(count == 16'd2, "R10 hold", count, 2);
        check(irq_total == 0, "R10 no irq", irq_total, 0);

        // R12 compare zero
        write_cmp(16'd0);
        @(negedge clk);
        cnt_en = 1'b1;
        cyc(2);
        pulses(1);
        check(count == 16'd0, "R12 first edge", count, 0);
        irq_total = 0;
        pulses(3);
        check(irq_total == 3, "R12 irq every edge", irq_total, 3);
        check(count == 16'd0, "R12 stays zero", count, 0);

        cyc(4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule